// File: doc/BRIEF.md
# Mode-Selectable System Clock Divider and Gater

This block turns one fast master clock into the clock groups that a board-level system clock generator drives: a host clock, a memory reference at half the host rate with its complement, a 66 MHz-class clock and a PCI-class clock. A frequency-select input picks one of two ratio sets. A divide-by-4 path serves the 133 setting and a divide-by-3 path serves the 100 setting. A free-running reference and a 48 MHz-class clock are brought in, synchronized into the master domain, and passed to their own outputs. Every output is registered in the master-clock domain.

Two strap bits are taken from pins that the 48 MHz-class outputs share on the board. They are captured only while reset is held. Together with the frequency select they choose one of three modes: normal running, all outputs disabled (high impedance, shown through per-group enables), or a test divide-down. In test mode the reference input acts as the test clock. An active-low power-down input passes through a synchronizer first. It then stops every output low, and it acts only between pulses, so no pulse is ever cut short.

Top module: `sysclk_divgate`

## Requirements
- R1: While rst_ni is low, the host, memory reference, 66-class, PCI, reference and 48 MHz-class outputs are all low.
- R2: With fsel_i=1 (133 setting) in normal mode, the periods counted in master cycles are: host 2, memory reference 4 (2 high), 66-class 4 (2 high), PCI 8 (4 high).
- R3: With fsel_i=0 (100 setting) in normal mode, the host period is 2 and the memory reference period is 4 (2 high). The 66-class period is 3, with 1 cycle high and 2 cycles low. The PCI period is 6, with 3 cycles high.
- R4: In normal mode, the 66-class output is high in the master cycle just before each PCI rising edge and low in the cycle before that. The 66-class edge therefore leads the PCI edge by exactly one master cycle.
- R5: mref_b_o is always the inverse of mref_o, and host_b_o is always the inverse of host_o. All copies within a group are equal.
- R6: strap_i is captured on clock edges while rst_ni is low. Strap 2'b11 with fsel_i=0 drives every bit of oe_o low. Every other strap code (00, 01, 10) with either select, and strap 11 with fsel_i=1, leaves oe_o all ones.
- R7: Changes on strap_i after reset has been released have no effect on oe_o or on the ratios until the next reset.
- R8: Strap 2'b11 with fsel_i=1 selects test mode, counted in rising edges of ref_i. Host toggles on every edge (ref/2). The memory reference and 66-class outputs run at ref/4. PCI runs at ref/8. The reference output follows ref_i.
- R9: The power-down input pd_ni is active low and is synchronized over two flops. Once it has been low for 5 cycles, no output makes a rising edge. The outputs sit low while it stays low, and they resume their normal ratios after it returns high.
- R10: Power-down stops and restarts each output only between pulses. Every high pulse therefore keeps its full width (66-class 2 cycles and PCI 4 cycles in the 133 setting).
- R11: In normal mode, ref_o follows ref_i and usb_o follows aux_i at their own periods.
- R12: A change of fsel_i clears the divide counters together. The new ratio set then takes effect with the R4 alignment intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (synthesizer output stand-in) |
| rst_ni | input | 1 | Asynchronous active-low reset; strap capture window |
| fsel_i | input | 1 | Frequency select: 1 = 133 setting, 0 = 100 setting |
| strap_i | input | 2 | Strap bits sensed on the shared 48 MHz-class pins |
| pd_ni | input | 1 | Active-low power-down request, asynchronous |
| ref_i | input | 1 | Free-running reference; test clock in test mode |
| aux_i | input | 1 | 48 MHz-class clock from its separate source |
| host_o | output | N_HOST | Host clock, true side |
| host_b_o | output | N_HOST | Host clock, complement side |
| mref_o | output | 1 | Memory reference, half host rate |
| mref_b_o | output | 1 | Inverse of mref_o |
| v66_o | output | N_V66 | 66 MHz-class clocks |
| pci_o | output | N_PCI | PCI-class clocks |
| ref_o | output | N_REF | Reference clock outputs |
| usb_o | output | N_USB | 48 MHz-class outputs |
| oe_o | output | 6 | Per-group drive enables: host, mref, 66, PCI, ref, 48 MHz |

## Verification
The bench samples whole periodic windows and counts rising edges and high cycles, so a wrong divide ratio or a wrong duty pattern changes the counts directly. An inverted 1-high/2-low pattern would show 64 high cycles where 32 are expected. The one-cycle lead of the 66-class clock over PCI is checked at every PCI edge, in both settings and right after a select change. A design that lost the counter alignment would show the lead drifting or reversing. Power-down is pulsed low for one to nine cycles at changing phases while a monitor records every high pulse. Gating on the wrong phase would show up as a pulse shorter than 2 or 4 cycles. Straps are changed after reset to show that they are ignored. A design that sampled them continuously would flip the enables or fall into test mode.

// File: rtl/sysclk_divgate_pkg.sv
`timescale 1ns/1ps
package sysclk_divgate_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HIZ  = 2'd1,
    MODE_TEST = 2'd2
  } mode_e;

  // output group index; order matches oe_o bits
  localparam int GRP_HOST = 0;
  localparam int GRP_MREF = 1;
  localparam int GRP_V66  = 2;
  localparam int GRP_PCI  = 3;
  localparam int GRP_REF  = 4;
  localparam int GRP_USB  = 5;
  localparam int N_GRP    = 6;

  // index into the divider's raw vector
  localparam int RAW_HOST = 0;
  localparam int RAW_MREF = 1;
  localparam int RAW_V66  = 2;
  localparam int RAW_PCI  = 3;
  localparam int N_RAW    = 4;

  function automatic mode_e decode_mode(logic fast, logic [1:0] strap);
    if (strap == 2'b11) return fast ? MODE_TEST : MODE_HIZ;
    return MODE_RUN;
  endfunction

endpackage

// File: rtl/sysclk_divgate_sync.sv
`timescale 1ns/1ps
module sysclk_divgate_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sysclk_divgate_ratio.sv
`timescale 1ns/1ps
module sysclk_divgate_ratio
  import sysclk_divgate_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             fast_i,
  input  logic             test_i,
  input  logic             tick_i,
  output logic [N_RAW-1:0] raw_o
);
  localparam int MAXD = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int CW   = $clog2(2 * MAXD);
  localparam logic [CW-1:0] DF     = CW'(DIV_FAST);
  localparam logic [CW-1:0] DS     = CW'(DIV_SLOW);
  localparam logic [CW-1:0] LAST_F = CW'(2 * DIV_FAST - 1);
  localparam logic [CW-1:0] LAST_S = CW'(2 * DIV_SLOW - 1);

  logic [CW-1:0] per_q;   // spans one PCI period (two 66 periods)
  logic [1:0]    host_q;  // host / memory reference phase
  logic [2:0]    tst_q;   // test-clock edge count

  logic [CW-1:0] div, last, sub;
  logic          v66_n, pci_n;

  assign div  = fast_i ? DF : DS;
  assign last = fast_i ? LAST_F : LAST_S;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      host_q <= '0;
      tst_q  <= '0;
    end else if (clr_i) begin
      per_q  <= '0;
      host_q <= '0;
      tst_q  <= '0;
    end else begin
      per_q  <= (per_q == last) ? '0 : per_q + 1'b1;
      host_q <= host_q + 2'd1;
      if (tick_i) tst_q <= tst_q + 3'd1;
    end
  end

  assign sub   = (per_q >= div) ? per_q - div : per_q;
  assign v66_n = sub < (div >> 1);
  // PCI high window starts one master cycle after the 66 rising phase
  assign pci_n = (per_q != '0) && (per_q <= div);

  always_comb begin
    if (test_i) begin
      raw_o[RAW_HOST] = tst_q[0];
      raw_o[RAW_MREF] = tst_q[1];
      raw_o[RAW_V66]  = tst_q[1];
      raw_o[RAW_PCI]  = tst_q[2];
    end else begin
      raw_o[RAW_HOST] = ~host_q[0];
      raw_o[RAW_MREF] = ~host_q[1];
      raw_o[RAW_V66]  = v66_n;
      raw_o[RAW_PCI]  = pci_n;
    end
  end
endmodule

// File: rtl/sysclk_divgate_gate.sv
`timescale 1ns/1ps
module sysclk_divgate_gate #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] out_o
);
  for (genvar g = 0; g < N; g++) begin : g_cell
    logic en_q, out_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q  <= 1'b0;
        out_q <= 1'b0;
      end else begin
        // enable may change only in the low phase: pulses stay whole
        if (!raw_i[g]) en_q <= run_i;
        out_q <= raw_i[g] & en_q;
      end
    end
    assign out_o[g] = out_q;
  end
endmodule

// File: rtl/sysclk_divgate.sv
`timescale 1ns/1ps
module sysclk_divgate
  import sysclk_divgate_pkg::*;
#(
  parameter int DIV_FAST    = 4,
  parameter int DIV_SLOW    = 3,
  parameter int N_HOST      = 4,
  parameter int N_V66       = 4,
  parameter int N_PCI       = 10,
  parameter int N_REF       = 2,
  parameter int N_USB       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsel_i,
  input  logic [1:0]        strap_i,
  input  logic              pd_ni,
  input  logic              ref_i,
  input  logic              aux_i,
  output logic [N_HOST-1:0] host_o,
  output logic [N_HOST-1:0] host_b_o,
  output logic              mref_o,
  output logic              mref_b_o,
  output logic [N_V66-1:0]  v66_o,
  output logic [N_PCI-1:0]  pci_o,
  output logic [N_REF-1:0]  ref_o,
  output logic [N_USB-1:0]  usb_o,
  output logic [N_GRP-1:0]  oe_o
);
  logic [1:0] strap_q;
  logic       fsel_q;
  mode_e      mode_q;
  logic       clr;

  // strap capture runs only inside the reset window
  always_ff @(posedge clk_i) begin
    if (!rst_ni) strap_q <= strap_i;
  end

  assign clr = fsel_i ^ fsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsel_q <= 1'b1;
      mode_q <= MODE_RUN;
    end else begin
      fsel_q <= fsel_i;
      mode_q <= decode_mode(fsel_q, strap_q);
    end
  end

  logic [2:0] async_in, async_s;
  logic       run, ref_s, aux_s, ref_d, tick;

  assign async_in = {pd_ni, aux_i, ref_i};

  sysclk_divgate_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (async_in),
    .q_o   (async_s)
  );

  assign {run, aux_s, ref_s} = async_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_d <= 1'b0;
    else         ref_d <= ref_s;
  end

  assign tick = ref_s & ~ref_d;

  logic [N_RAW-1:0] div_raw;

  sysclk_divgate_ratio #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_ratio (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .fast_i(fsel_q),
    .test_i(mode_q == MODE_TEST),
    .tick_i(tick),
    .raw_o (div_raw)
  );

  logic [N_GRP-1:0] grp_raw, grp_out;

  always_comb begin
    grp_raw           = '0;
    grp_raw[GRP_HOST] = div_raw[RAW_HOST];
    grp_raw[GRP_MREF] = div_raw[RAW_MREF];
    grp_raw[GRP_V66]  = div_raw[RAW_V66];
    grp_raw[GRP_PCI]  = div_raw[RAW_PCI];
    grp_raw[GRP_REF]  = ref_s;
    grp_raw[GRP_USB]  = aux_s;
  end

  sysclk_divgate_gate #(.N(N_GRP)) u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .raw_i (grp_raw),
    .out_o (grp_out)
  );

  assign host_o   = {N_HOST{grp_out[GRP_HOST]}};
  assign host_b_o = ~host_o;
  assign mref_o   = grp_out[GRP_MREF];
  assign mref_b_o = ~mref_o;
  assign v66_o    = {N_V66{grp_out[GRP_V66]}};
  assign pci_o    = {N_PCI{grp_out[GRP_PCI]}};
  assign ref_o    = {N_REF{grp_out[GRP_REF]}};
  assign usb_o    = {N_USB{grp_out[GRP_USB]}};
  assign oe_o     = {N_GRP{mode_q != MODE_HIZ}};
endmodule

// File: rtl/sysclk_divgate_chk.sv
`timescale 1ns/1ps
module sysclk_divgate_chk
  import sysclk_divgate_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fsel_i,
  input logic             pd_ni,
  input logic [1:0]       mode_i,
  input logic             host_i,
  input logic             mref_i,
  input logic             v66_i,
  input logic             pci_i,
  input logic             ref_i,
  input logic             usb_i,
  input logic [N_GRP-1:0] oe_i
);
  logic [3:0] since_rst, pd_lo_cnt, pd_hi_cnt, stab_cnt;
  logic [1:0] mode_d;
  logic       fsel_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= '0;
      pd_lo_cnt <= '0;
      pd_hi_cnt <= '0;
      stab_cnt  <= '0;
      mode_d    <= '0;
      fsel_d    <= 1'b0;
    end else begin
      mode_d <= mode_i;
      fsel_d <= fsel_i;
      if (since_rst != 4'hf) since_rst <= since_rst + 4'd1;
      pd_lo_cnt <= pd_ni ? 4'd0 : ((pd_lo_cnt == 4'hf) ? pd_lo_cnt : pd_lo_cnt + 4'd1);
      pd_hi_cnt <= !pd_ni ? 4'd0 : ((pd_hi_cnt == 4'hf) ? pd_hi_cnt : pd_hi_cnt + 4'd1);
      if (mode_i != mode_d || fsel_i != fsel_d) stab_cnt <= '0;
      else if (stab_cnt != 4'hf)                stab_cnt <= stab_cnt + 4'd1;
    end
  end

  // R9
  pd_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_lo_cnt >= 4'd5) |-> !$rose(host_i) && !$rose(mref_i) && !$rose(v66_i)
                          && !$rose(pci_i) && !$rose(ref_i) && !$rose(usb_i));

  // R7
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 4'd6 && fsel_i == $past(fsel_i) && $past(fsel_i) == $past(fsel_i, 2)
     && $past(fsel_i, 2) == $past(fsel_i, 3)) |-> $stable(oe_i));

  // R4
  v66_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stab_cnt >= 4'd8 && pd_hi_cnt >= 4'd8 && mode_i == MODE_RUN && $rose(pci_i))
      |-> $past(v66_i));

  // R10
  v66_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stab_cnt >= 4'd8 && mode_i == MODE_RUN && fsel_i && $fell(v66_i))
      |-> $past(v66_i, 2));

  // R10
  pci_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stab_cnt >= 4'd8 && mode_i == MODE_RUN && fsel_i && $fell(pci_i))
      |-> $past(pci_i, 4));
endmodule

bind sysclk_divgate sysclk_divgate_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .fsel_i(fsel_i),
  .pd_ni (pd_ni),
  .mode_i(mode_q),
  .host_i(host_o[0]),
  .mref_i(mref_o),
  .v66_i (v66_o[0]),
  .pci_i (pci_o[0]),
  .ref_i (ref_o[0]),
  .usb_i (usb_o[0]),
  .oe_i  (oe_o)
);

// File: tb/sysclk_divgate_bench.sv
`timescale 1ns/1ps
module sysclk_divgate_bench;
  localparam int N_HOST = 4, N_V66 = 4, N_PCI = 10, N_REF = 2, N_USB = 2;
  localparam int MAXS = 129;

  logic clk = 1'b0, rst_n = 1'b0, fsel = 1'b1, pd_n = 1'b1, ref_r = 1'b0, aux_r = 1'b0;
  logic [1:0] strap = 2'b00;
  logic [N_HOST-1:0] host, host_b;
  logic mref, mref_b;
  logic [N_V66-1:0] v66;
  logic [N_PCI-1:0] pci;
  logic [N_REF-1:0] refo;
  logic [N_USB-1:0] usb;
  logic [5:0] oe;

  int checks = 0, errors = 0, inv_err = 0;
  logic [5:0] smp [MAXS];   // 0 host,1 mref,2 66,3 pci,4 ref,5 usb
  int mon_en = 0;

  always #5 clk = ~clk;

  sysclk_divgate u_sysclk_divgate (
    .clk_i(clk), .rst_ni(rst_n), .fsel_i(fsel), .strap_i(strap), .pd_ni(pd_n),
    .ref_i(ref_r), .aux_i(aux_r), .host_o(host), .host_b_o(host_b), .mref_o(mref),
    .mref_b_o(mref_b), .v66_o(v66), .pci_o(pci), .ref_o(refo), .usb_o(usb), .oe_o(oe)
  );

  initial forever begin repeat (4) @(negedge clk); ref_r = ~ref_r; end
  initial forever begin repeat (2) @(negedge clk); aux_r = ~aux_r; end

  // high-pulse width monitor for R10
  int v_run = 0, p_run = 0, v_min = 99, v_max = 0, p_min = 99, p_max = 0;
  bit v_arm = 0, p_arm = 0;
  always @(negedge clk) begin
    if (mon_en == 0) begin
      v_arm = 0; p_arm = 0; v_run = 0; p_run = 0;
    end else begin
      if (v66[0]) begin if (v_arm) v_run++; end
      else begin
        if (v_arm && v_run > 0) begin
          if (v_run < v_min) v_min = v_run;
          if (v_run > v_max) v_max = v_run;
        end
        v_run = 0; v_arm = 1;
      end
      if (pci[0]) begin if (p_arm) p_run++; end
      else begin
        if (p_arm && p_run > 0) begin
          if (p_run < p_min) p_min = p_run;
          if (p_run > p_max) p_max = p_run;
        end
        p_run = 0; p_arm = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] s, input logic f);
    @(negedge clk);
    rst_n = 1'b0; strap = s; fsel = f; pd_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1
    chk({host[0], mref, v66[0], pci[0], refo[0], usb[0]} == 6'b0, "R1 outputs low in reset",
        int'({host[0], mref, v66[0], pci[0], refo[0], usb[0]}), 0);
    rst_n = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic capture(input int n);
    inv_err = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp[i] = {usb[0], refo[0], pci[0], v66[0], mref, host[0]};
      if (mref_b !== ~mref || host_b !== ~host) inv_err++;
      if (host !== {N_HOST{host[0]}} || v66 !== {N_V66{v66[0]}} || pci !== {N_PCI{pci[0]}}
          || refo !== {N_REF{refo[0]}} || usb !== {N_USB{usb[0]}}) inv_err++;
    end
  endtask

  task automatic count(input int b, input int n, output int rises, output int highs);
    rises = 0; highs = 0;
    for (int i = 0; i < n - 1; i++) if (smp[i][b]) highs++;
    for (int i = 1; i < n; i++) if (!smp[i-1][b] && smp[i][b]) rises++;
  endtask

  task automatic chk_group(input string req, input int n, input int exp_r[6], input int exp_h[6]);
    int r, h;
    for (int b = 0; b < 6; b++) begin
      count(b, n, r, h);
      chk(r == exp_r[b], $sformatf("%s rises grp%0d", req, b), r, exp_r[b]);
      chk(h == exp_h[b], $sformatf("%s highs grp%0d", req, b), h, exp_h[b]);
    end
  endtask

  task automatic chk_lead(input string req, input int n);
    int bad = 0, seen = 0;
    for (int i = 2; i < n; i++)
      if (!smp[i-1][3] && smp[i][3]) begin
        seen++;
        if (!(smp[i-1][2] && !smp[i-2][2])) bad++;
      end
    chk(bad == 0 && seen > 0, req, bad, 0);
  endtask

  task automatic t_fast;
    do_reset(2'b00, 1'b1);
    chk(oe == 6'h3f, "R6 oe on in normal", int'(oe), 63);
    capture(97);
    chk_group("R2/R11 fast", 97, '{48, 24, 24, 12, 12, 24}, '{48, 48, 48, 48, 48, 48});
    chk_lead("R4 lead fast", 97);
    chk(inv_err == 0, "R5 complements and copies", inv_err, 0);
  endtask

  task automatic t_slow;
    @(negedge clk); fsel = 1'b0;
    capture(97);
    chk_lead("R12 lead right after select change", 97);
    capture(97);
    chk_group("R3 slow", 97, '{48, 24, 32, 16, 12, 24}, '{48, 48, 32, 48, 48, 48});
    chk_lead("R4 lead slow", 97);
    chk(inv_err == 0, "R5 complements slow", inv_err, 0);
  endtask

  task automatic t_hiz_test;
    do_reset(2'b11, 1'b0);
    chk(oe == 6'h00, "R6 strap 11 sel 0 disables all", int'(oe), 0);
    @(negedge clk); strap = 2'b00;
    repeat (10) @(negedge clk);
    chk(oe == 6'h00, "R7 late strap ignored in hiz", int'(oe), 0);
    @(negedge clk); fsel = 1'b1;
    repeat (40) @(negedge clk);
    chk(oe == 6'h3f, "R8 test mode enables", int'(oe), 63);
    capture(129);
    chk_group("R8 test", 129, '{8, 4, 4, 2, 16, 32}, '{64, 64, 64, 64, 64, 64});
  endtask

  task automatic t_late_strap;
    do_reset(2'b00, 1'b1);
    @(negedge clk); strap = 2'b11;
    repeat (10) @(negedge clk);
    chk(oe == 6'h3f, "R7 late strap keeps oe", int'(oe), 63);
    capture(97);
    chk_group("R7 still normal ratios", 97, '{48, 24, 24, 12, 12, 24}, '{48, 48, 48, 48, 48, 48});
  endtask

  task automatic t_powerdown;
    do_reset(2'b01, 1'b1);
    @(negedge clk); mon_en = 1;
    for (int k = 1; k <= 9; k++) begin
      pd_n = 1'b0; repeat (k) @(negedge clk);
      pd_n = 1'b1; repeat (k + 6) @(negedge clk);
    end
    pd_n = 1'b0;
    repeat (40) @(negedge clk);
    capture(97);
    chk_group("R9 held low", 97, '{0, 0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0, 0});
    pd_n = 1'b1;
    repeat (20) @(negedge clk);
    mon_en = 0;
    capture(97);
    chk_group("R9 resume", 97, '{48, 24, 24, 12, 12, 24}, '{48, 48, 48, 48, 48, 48});
    chk(v_min == 2 && v_max == 2, "R10 66 pulse width min", v_min, 2);
    chk(p_min == 4 && p_max == 4, "R10 pci pulse width min", p_min, 4);
  endtask

  initial begin
    fork
      begin
        t_fast();
        t_slow();
        t_hiz_test();
        t_late_strap();
        t_powerdown();
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule